// File: doc/BRIEF.md
# Packed SIMD Vector ALU with Run-Time Element Width

This block is the arithmetic stage of a vector unit. It takes two source vectors, each made of `LANES` 32-bit lanes, and applies one operation to every element of both at once. The element width is chosen per operation from 8, 16, 32 or 64 bits, so the same hardware treats a vector either as many bytes or as a few wide words. In 64-bit mode each pair of neighbouring 32-bit lanes forms one element, which is why `LANES` must be even.

Carries, borrows and shifted-out bits stop at the element boundary currently selected. Logic operations act bit by bit and do not depend on the width. The multiplier is optional. An operation code outside the supported set raises the illegal flag and gives an all-zero result. Operands presented in one clock cycle produce their result on the outputs after the next rising edge, with no handshake.

Top module: `vsimd_alu`

## Requirements
- R1: The width code selects the element size: 2'b00 gives 8 bits, 2'b01 16 bits, 2'b10 32 bits and 2'b11 64 bits. Operation codes are 4'b0000 add, 4'b0010 subtract, 4'b1000 AND, 4'b1001 OR, 4'b1010 XOR, 4'b1011 multiply, 4'b1100 shift left and 4'b1110 shift right.
- R2: Add gives, in every element, the sum of the two source elements modulo 2 to the element width. No carry passes into the next element.
- R3: Subtract gives, in every element, first source minus second source modulo 2 to the element width. No borrow passes into the next element.
- R4: AND, OR and XOR give the bitwise result over the whole vector, whatever the width code is.
- R5: Shift left moves each element of the first source up by one bit, puts 0 in the element's lowest bit and drops the element's top bit.
- R6: Shift right moves each element of the first source down by one bit, puts 0 in the element's top bit and drops the element's lowest bit.
- R7: When `HAS_MUL` is 1, multiply gives in each element the low element-width bits of the product of the two source elements.
- R8: Any other operation code, and multiply when `HAS_MUL` is 0, sets `illegalOp` to 1 and the result to all zeros. Every supported code clears `illegalOp`.
- R9: Outputs show the result of the inputs sampled at the previous rising clock edge. While `rstN` is low, `result` and `illegalOp` are 0.
- R10: In 64-bit mode, lanes 2j and 2j+1 form one element with lane 2j as its low half. Carries and shifted bits cross between those two lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| srcA | input | LANES*32 | First source vector, lane 0 in the low bits |
| srcB | input | LANES*32 | Second source vector |
| widthSel | input | 2 | Element width code |
| opCode | input | 4 | Operation code |
| result | output | LANES*32 | Registered result vector |
| illegalOp | output | 1 | Registered illegal-operation flag |

## Verification
The assertions assume that `srcA`, `srcB`, `opCode` and `widthSel` have known values at every rising edge after reset. They also assume the inputs are not touched between the drive point and the sampling edge. The bench drives all inputs to defined values before reset is released and changes them only on falling edges. Every operation code, all 16 of them, is paired with every width code. Carry-heavy patterns such as all-ones plus one are placed at each width so that a carry leak across an element boundary would show in the result.

// File: rtl/vsimd_pkg.sv
package vsimd_pkg;
  localparam int LANE_BITS  = 32;
  localparam int CHUNK_BITS = 64;

  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doAnd;
    logic doOr;
    logic doXor;
    logic doMul;
    logic doShl;
    logic doShr;
    logic bad;
    logic [1:0] width;
  } vsimd_ctrl_t;
endpackage

// File: rtl/vsimd_ctrl.sv
module vsimd_ctrl
  import vsimd_pkg::*;
#(
  parameter bit HAS_MUL = 1'b1
) (
  input  logic [3:0]  opCode,
  input  logic [1:0]  widthSel,
  output vsimd_ctrl_t ctrl
);
  always_comb begin
    ctrl       = '0;
    ctrl.width = widthSel;
    unique case (opCode)
      4'b0000: ctrl.doAdd = 1'b1;
      4'b0010: ctrl.doSub = 1'b1;
      4'b1000: ctrl.doAnd = 1'b1;
      4'b1001: ctrl.doOr  = 1'b1;
      4'b1010: ctrl.doXor = 1'b1;
      4'b1011: begin
        ctrl.doMul = HAS_MUL;
        ctrl.bad   = !HAS_MUL;
      end
      4'b1100: ctrl.doShl = 1'b1;
      4'b1110: ctrl.doShr = 1'b1;
      default: ctrl.bad   = 1'b1;
    endcase
  end

  // R8: exactly one strobe or the bad flag for every known opcode
  always_comb begin
    if (!$isunknown(opCode)) begin
      assert_one_strobe_R8: assert ($onehot({ctrl.doAdd, ctrl.doSub, ctrl.doAnd, ctrl.doOr,
                                              ctrl.doXor, ctrl.doMul, ctrl.doShl, ctrl.doShr,
                                              ctrl.bad}));
    end
  end
endmodule

// File: rtl/vsimd_elem.sv
module vsimd_elem
  import vsimd_pkg::*;
#(
  parameter int  EW      = 8,
  parameter bit  HAS_MUL = 1'b1
) (
  input  vsimd_ctrl_t   ctrl,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] y
);
  logic [EW-1:0] prodLow;

  generate
    if (HAS_MUL) begin : g_mul
      logic [2*EW-1:0] prodFull;
      assign prodFull = a * b;
      assign prodLow  = prodFull[EW-1:0];
    end else begin : g_nomul
      assign prodLow = '0;
    end
  endgenerate

  always_comb begin
    y = '0;
    if (ctrl.doAdd) y = a + b;
    if (ctrl.doSub) y = a - b;
    if (ctrl.doAnd) y = a & b;
    if (ctrl.doOr)  y = a | b;
    if (ctrl.doXor) y = a ^ b;
    if (ctrl.doMul) y = prodLow;
    if (ctrl.doShl) y = {a[EW-2:0], 1'b0};
    if (ctrl.doShr) y = {1'b0, a[EW-1:1]};
  end
endmodule

// File: rtl/vsimd_datapath.sv
module vsimd_datapath
  import vsimd_pkg::*;
#(
  parameter int LANES   = 2,
  parameter bit HAS_MUL = 1'b1
) (
  input  vsimd_ctrl_t             ctrl,
  input  logic [LANES*LANE_BITS-1:0] a,
  input  logic [LANES*LANE_BITS-1:0] b,
  output logic [LANES*LANE_BITS-1:0] y
);
  localparam int CHUNKS = LANES / 2;

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    logic [3:0][CHUNK_BITS-1:0] byWidth;
    logic [CHUNK_BITS-1:0]      chunkA, chunkB;

    assign chunkA = a[c*CHUNK_BITS +: CHUNK_BITS];
    assign chunkB = b[c*CHUNK_BITS +: CHUNK_BITS];

    for (genvar w = 0; w < 4; w++) begin : g_width
      localparam int EW    = 8 << w;
      localparam int COUNT = CHUNK_BITS / EW;
      for (genvar e = 0; e < COUNT; e++) begin : g_elem
        vsimd_elem #(.EW(EW), .HAS_MUL(HAS_MUL)) u_elem (
          .ctrl (ctrl),
          .a    (chunkA[e*EW +: EW]),
          .b    (chunkB[e*EW +: EW]),
          .y    (byWidth[w][e*EW +: EW])
        );
      end
    end

    assign y[c*CHUNK_BITS +: CHUNK_BITS] = byWidth[ctrl.width];
  end
endmodule

// File: rtl/vsimd_alu.sv
module vsimd_alu
  import vsimd_pkg::*;
#(
  parameter int LANES   = 2,
  parameter bit HAS_MUL = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LANES*32-1:0]      srcA,
  input  logic [LANES*32-1:0]      srcB,
  input  logic [1:0]               widthSel,
  input  logic [3:0]               opCode,
  output logic [LANES*32-1:0]      result,
  output logic                     illegalOp
);
  localparam int VW = LANES * LANE_BITS;

  vsimd_ctrl_t   ctrl;
  logic [VW-1:0] dpOut;
  logic          primed;

  vsimd_ctrl #(.HAS_MUL(HAS_MUL)) u_ctrl (
    .opCode   (opCode),
    .widthSel (widthSel),
    .ctrl     (ctrl)
  );

  vsimd_datapath #(.LANES(LANES), .HAS_MUL(HAS_MUL)) u_dp (
    .ctrl (ctrl),
    .a    (srcA),
    .b    (srcB),
    .y    (dpOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      illegalOp <= 1'b0;
      primed    <= 1'b0;
    end else begin
      result    <= ctrl.bad ? '0 : dpOut;
      illegalOp <= ctrl.bad;
      primed    <= 1'b1;
    end
  end

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    primed && illegalOp |-> result == '0);

  assert_and_bitwise_R4: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opCode) == 4'b1000 |-> result == ($past(srcA) & $past(srcB)));

  assert_add_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opCode) == 4'b0000 && $past(srcB) == '0 |-> result == $past(srcA));

  assert_shl_low_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opCode) == 4'b1100 |-> result[0] == 1'b0);

  assert_shr_top_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opCode) == 4'b1110 |-> result[VW-1] == 1'b0);
endmodule

// File: tb/vsimd_alu_tb.sv
module vsimd_alu_tb;
  localparam int LANES = 4;
  localparam int VW    = LANES * 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [VW-1:0] srcA = '0, srcB = '0;
  logic [1:0]    widthSel = '0;
  logic [3:0]    opCode = '0;
  logic [VW-1:0] result;
  logic          illegalOp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [VW-1:0] expQ[$];
  logic          expBadQ[$];
  string         tagQ[$];

  always #2.5 clk = ~clk;

  vsimd_alu #(.LANES(LANES), .HAS_MUL(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB),
    .widthSel(widthSel), .opCode(opCode),
    .result(result), .illegalOp(illegalOp)
  );

  function automatic void refModel(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                   input logic [3:0] op, input logic [1:0] w,
                                   output logic [VW-1:0] r, output logic bad, output string tag);
    int ew = 8 << w;
    longint unsigned mask = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 1);
    r = '0;
    bad = 1'b0;
    case (op)
      4'b0000: tag = "R2";
      4'b0010: tag = "R3";
      4'b1000, 4'b1001, 4'b1010: tag = "R4";
      4'b1011: tag = "R7";
      4'b1100: tag = "R5";
      4'b1110: tag = "R6";
      default: begin tag = "R8"; bad = 1'b1; end
    endcase
    if (w == 2'b11 && !bad) tag = {tag, " R10"};
    tag = {"R1 ", tag};
    if (bad) return;
    for (int c = 0; c < VW / 64; c++) begin
      longint unsigned ca = a[c*64 +: 64];
      longint unsigned cb = b[c*64 +: 64];
      longint unsigned cr = 0;
      for (int e = 0; e < 64 / ew; e++) begin
        longint unsigned x = (ca >> (e*ew)) & mask;
        longint unsigned z = (cb >> (e*ew)) & mask;
        longint unsigned y;
        case (op)
          4'b0000: y = x + z;
          4'b0010: y = x - z;
          4'b1000: y = x & z;
          4'b1001: y = x | z;
          4'b1010: y = x ^ z;
          4'b1011: y = x * z;
          4'b1100: y = x << 1;
          default: y = x >> 1;
        endcase
        cr |= (y & mask) << (e*ew);
      end
      r[c*64 +: 64] = cr;
    end
  endfunction

  task automatic compare(input logic [VW-1:0] er, input logic eb, input string tag);
    checks++;
    if (result !== er || illegalOp !== eb) begin
      fails++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               tag, result, illegalOp, er, eb);
    end
  endtask

  task automatic apply(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [3:0] op, input logic [1:0] w);
    logic [VW-1:0] r;
    logic bad;
    string tag;
    @(negedge clk);
    if (expQ.size() > 0) compare(expQ.pop_front(), expBadQ.pop_front(), tagQ.pop_front());
    srcA = a; srcB = b; opCode = op; widthSel = w;
    refModel(a, b, op, w, r, bad, tag);
    expQ.push_back(r); expBadQ.push_back(bad); tagQ.push_back(tag);
  endtask

  function automatic logic [VW-1:0] rnd();
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    logic [VW-1:0] allOnes = '1;
    logic [VW-1:0] one = {{(VW-1){1'b0}}, 1'b1};
    srcA = allOnes; srcB = allOnes; opCode = 4'b0000;
    repeat (3) @(negedge clk);
    compare('0, 1'b0, "R9 reset");
    rstN = 1'b1;
    // carry / borrow containment at every width
    for (int w = 0; w < 4; w++) begin
      apply(allOnes, {LANES*4{8'h01}}, 4'b0000, w[1:0]);
      apply('0, {LANES*4{8'h01}}, 4'b0010, w[1:0]);
      apply({LANES*2{16'h8001}}, '0, 4'b1100, w[1:0]);
      apply({LANES*2{16'h8001}}, '0, 4'b1110, w[1:0]);
      apply(allOnes, allOnes, 4'b1011, w[1:0]);
      apply({LANES{32'hF0F0_1234}}, {LANES{32'h0FF0_4321}}, 4'b1010, w[1:0]);
    end
    apply({LANES{32'hFFFF_FFFF}}, one, 4'b0000, 2'b11);   // R10 carry into upper lane
    apply({LANES/2{64'h0000_0000_8000_0000}}, '0, 4'b1100, 2'b11);
    apply({LANES/2{64'h0000_0001_0000_0000}}, '0, 4'b1110, 2'b11);
    for (int op = 0; op < 16; op++)
      for (int w = 0; w < 4; w++)
        apply(rnd(), rnd(), op[3:0], w[1:0]);
    for (int i = 0; i < 600; i++)
      apply(rnd(), rnd(), 4'($urandom()), 2'($urandom()));
    @(negedge clk);
    compare(expQ.pop_front(), expBadQ.pop_front(), tagQ.pop_front());
    // R9: reset clears outputs
    srcA = allOnes; srcB = allOnes; opCode = 4'b0000; widthSel = 2'b00;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    compare('0, 1'b0, "R9 reset again");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule